// File: doc/BRIEF.md
# Framed Serial Octal Register Loader

This block accepts 16-bit command words over a three-wire serial link (an active-low frame-select, a serial clock and a data line) and writes them into a bank of eight channel registers of an octal converter. Each word either loads a 12-bit code into one of the eight staging registers or updates a small reference-configuration register shared by two groups of four channels. The serial pins are oversampled by the fast system clock through two-flop synchronizers, and the bits are taken on the falling edges of the serial clock. The serial clock must therefore stay well below half the system clock rate.

The staging registers feed a second bank of output registers through an active-low load strobe. Pulsing the strobe low copies all eight staging values to the outputs at once, so every channel changes together. Holding the strobe low makes the output bank follow the staging bank, so a completed write reaches its output straight away. A frame that is released before its sixteenth falling clock edge is discarded. Clock edges after the sixteenth in the same frame are ignored.

Top module: `octal_reg_loader`

## Requirements
- R1: While and after reset, every output code, both reference-buffer flags and both supply-reference flags read zero.
- R2: A data word has bit 15 = 0, bits 14:12 = channel number (0 = A … 7 = H) and bits 11:0 = code, shifted in MSB first on the 16 serial clock falling edges after frame-select falls. It writes only that channel's staging register. Output channel i appears on out_codes[i*12 +: 12].
- R3: If frame-select rises before the sixteenth falling edge, no staging, output or configuration register changes.
- R4: Falling edges after the sixteenth in a frame are ignored. A further word is only accepted after frame-select goes high and low again.
- R5: While the load strobe is high, the output codes do not change, whatever words are written.
- R6: A low pulse on the load strobe copies all eight staging registers into the output registers in the same cycle.
- R7: While the load strobe is held low, an output follows its staging register within a few system cycles of the write completing.
- R8: A control word has bit 15 = 1. Bit 0 sets the reference-buffer flag of channels A–D, bit 1 the flag of E–H, bit 2 the supply-reference flag of A–D and bit 3 the supply-reference flag of E–H. A control word leaves every staging register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Active-low frame select |
| ser_clk | input | 1 | Serial clock; data is taken on its falling edge |
| ser_dat | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Active-low staging-to-output transfer strobe |
| out_codes | output | 96 | Eight 12-bit output register values, channel A in the low bits |
| ref_buffered | output | 2 | Reference-buffer flag per group (bit 0 = A–D, bit 1 = E–H) |
| ref_from_supply | output | 2 | Supply-as-reference flag per group (bit 0 = A–D, bit 1 = E–H) |

## Verification
The staging registers cannot be seen at the ports while the load strobe is high. A dropped or misrouted write only shows up after a later transfer pulse, and only if nothing has overwritten it in between. The stimulus therefore mixes aborted frames of random length, over-long frames and control words with sparse load pulses, and compares every channel after each step. It also runs a transparent phase with the strobe held low, so that each write can be compared on its own output.

// File: rtl/olr_pkg.sv
package olr_pkg;

    // Number of channel groups that share a reference configuration
    localparam int unsigned GRP_N = 2;

    // Reference configuration: bits [GRP_N-1:0] buffered, next GRP_N bits supply
    typedef struct packed {
        logic [GRP_N-1:0] from_supply;
        logic [GRP_N-1:0] buffered;
    } ref_cfg_t;

    localparam int unsigned CFG_W = $bits(ref_cfg_t);

endpackage

// File: rtl/olr_sync.sv
module olr_sync #(
    parameter int unsigned       W       = 1,
    parameter logic [W-1:0]      RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.meta   = async_i;
        sy_d.stable = sy_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '{meta: RST_VAL, stable: RST_VAL};
        end else begin
            sy_q <= sy_d;
        end
    end

    assign sync_o = sy_q.stable;

endmodule

// File: rtl/olr_deser.sv
module olr_deser #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_s,
    input  logic              sclk_s,
    input  logic              sdat_s,
    output logic              word_valid,
    output logic [WORD_W-1:0] word
);

    localparam int unsigned CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic              sclk_prev;
        logic [CNT_W-1:0]  cnt;
        logic              done;
        logic [WORD_W-1:0] shreg;
        logic              valid;
    } deser_t;

    deser_t ds_d, ds_q;
    logic   sclk_fall;

    always_comb begin
        ds_d           = ds_q;
        ds_d.valid     = 1'b0;
        ds_d.sclk_prev = sclk_s;
        sclk_fall      = ds_q.sclk_prev && !sclk_s;

        if (frame_s) begin
            // frame idle or released: any partial word is abandoned
            ds_d.cnt  = '0;
            ds_d.done = 1'b0;
        end else if (sclk_fall && !ds_q.done) begin
            ds_d.shreg = {ds_q.shreg[WORD_W-2:0], sdat_s};
            if (ds_q.cnt == LAST) begin
                ds_d.cnt   = '0;
                ds_d.done  = 1'b1;
                ds_d.valid = 1'b1;
            end else begin
                ds_d.cnt = ds_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ds_q <= '{sclk_prev: 1'b1, cnt: '0, done: 1'b0, shreg: '0, valid: 1'b0};
        end else begin
            ds_q <= ds_d;
        end
    end

    assign word_valid = ds_q.valid;
    assign word       = ds_q.shreg;

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ds_q.cnt <= LAST);

    // R4
    single_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R3
    abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_s |=> (ds_q.cnt == '0 && !word_valid && !ds_q.done));

endmodule

// File: rtl/olr_bank.sv
module olr_bank
    import olr_pkg::*;
#(
    parameter int unsigned CH_N   = 8,
    parameter int unsigned DATA_W = 12,
    parameter int unsigned ADDR_W = $clog2(CH_N),
    parameter int unsigned WORD_W = 1 + ADDR_W + DATA_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     word_valid,
    input  logic [WORD_W-1:0]        word,
    input  logic                     load_s,
    output logic [CH_N*DATA_W-1:0]   out_codes,
    output ref_cfg_t                 ref_cfg
);

    typedef struct packed {
        logic [CH_N-1:0][DATA_W-1:0] stage;
        logic [CH_N-1:0][DATA_W-1:0] outr;
        ref_cfg_t                    cfg;
    } bank_t;

    bank_t            bk_d, bk_q;
    logic             is_ctrl;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] code;

    assign is_ctrl = word[WORD_W-1];
    assign addr    = word[WORD_W-2 -: ADDR_W];
    assign code    = word[DATA_W-1:0];

    always_comb begin
        bk_d = bk_q;
        if (word_valid) begin
            if (is_ctrl) begin
                bk_d.cfg = ref_cfg_t'(word[CFG_W-1:0]);
            end else begin
                bk_d.stage[addr] = code;
            end
        end
        // level-sensitive transfer: transparent while the strobe is low
        if (!load_s) begin
            bk_d.outr = bk_q.stage;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign out_codes = bk_q.outr;
    assign ref_cfg   = bk_q.cfg;

    // R2
    data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !is_ctrl) |=> bk_q.stage[$past(addr)] == $past(code));

    // R8
    ctrl_no_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && is_ctrl) |=> $stable(bk_q.stage));

    // R5
    hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_s |=> $stable(bk_q.outr));

    // R6
    transfer_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_s |=> bk_q.outr == $past(bk_q.stage));

endmodule

// File: rtl/octal_reg_loader.sv
module octal_reg_loader
    import olr_pkg::*;
#(
    parameter int unsigned CH_N   = 8,
    parameter int unsigned DATA_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_n,
    input  logic                    ser_clk,
    input  logic                    ser_dat,
    input  logic                    load_n,
    output logic [CH_N*DATA_W-1:0]  out_codes,
    output logic [GRP_N-1:0]        ref_buffered,
    output logic [GRP_N-1:0]        ref_from_supply
);

    localparam int unsigned ADDR_W = $clog2(CH_N);
    localparam int unsigned WORD_W = 1 + ADDR_W + DATA_W;

    logic [2:0]        ctl_sync;
    logic [0:0]        dat_sync;
    logic              word_valid;
    logic [WORD_W-1:0] word;
    ref_cfg_t          cfg;

    // frame select, serial clock and load strobe idle high
    olr_sync #(.W(3), .RST_VAL(3'b111)) u_ctl_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({frame_n, ser_clk, load_n}),
        .sync_o  (ctl_sync)
    );

    olr_sync #(.W(1), .RST_VAL(1'b0)) u_dat_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ser_dat),
        .sync_o  (dat_sync)
    );

    olr_deser #(.WORD_W(WORD_W)) u_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_s    (ctl_sync[2]),
        .sclk_s     (ctl_sync[1]),
        .sdat_s     (dat_sync[0]),
        .word_valid (word_valid),
        .word       (word)
    );

    olr_bank #(
        .CH_N   (CH_N),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (word_valid),
        .word       (word),
        .load_s     (ctl_sync[0]),
        .out_codes  (out_codes),
        .ref_cfg    (cfg)
    );

    assign ref_buffered    = cfg.buffered;
    assign ref_from_supply = cfg.from_supply;

endmodule

// File: tb/octal_reg_loader_test.sv
module octal_reg_loader_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        ser_clk = 1'b1;
    logic        ser_dat = 1'b0;
    logic        load_n = 1'b1;
    logic [95:0] out_codes;
    logic [1:0]  ref_buffered;
    logic [1:0]  ref_from_supply;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    logic [11:0] exp_stage [8];
    logic [11:0] exp_out   [8];
    logic [3:0]  exp_cfg = 4'h0;
    bit          transparent = 1'b0;

    always #2.5 clk = ~clk;

    octal_reg_loader uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .frame_n         (frame_n),
        .ser_clk         (ser_clk),
        .ser_dat         (ser_dat),
        .load_n          (load_n),
        .out_codes       (out_codes),
        .ref_buffered    (ref_buffered),
        .ref_from_supply (ref_from_supply)
    );

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                failures++;
                $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
                finish_run();
            end
        end
    end

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // expected effect of one completed word
    function automatic void apply_word(input logic [15:0] w);
        if (w[15]) exp_cfg = w[3:0];
        else       exp_stage[w[14:12]] = w[11:0];
        if (transparent) begin
            for (int i = 0; i < 8; i++) exp_out[i] = exp_stage[i];
        end
    endfunction

    // nbits < 16 aborts; nbits > 16 adds ignored random bits
    task automatic send_frame(input logic [15:0] w, input int nbits);
        frame_n = 1'b0;
        wait_clks(4);
        for (int i = 0; i < nbits; i++) begin
            ser_dat = (i < 16) ? w[15-i] : 1'($urandom);
            wait_clks(3);
            ser_clk = 1'b0;
            wait_clks(3);
            ser_clk = 1'b1;
        end
        wait_clks(3);
        frame_n = 1'b1;
        wait_clks(8);
        if (nbits >= 16) apply_word(w);
    endtask

    task automatic pulse_load();
        load_n = 1'b0;
        wait_clks(6);
        load_n = 1'b1;
        wait_clks(6);
        for (int i = 0; i < 8; i++) exp_out[i] = exp_stage[i];
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 8; i++) begin
            checks++;
            if (out_codes[i*12 +: 12] !== exp_out[i]) begin
                failures++;
                $display("FAIL %s ch%0d: actual=%h expected=%h", tag, i,
                         out_codes[i*12 +: 12], exp_out[i]);
            end
        end
        checks++;
        if ({ref_from_supply, ref_buffered} !== exp_cfg) begin
            failures++;
            $display("FAIL %s cfg: actual=%h expected=%h", tag,
                     {ref_from_supply, ref_buffered}, exp_cfg);
        end
    endtask

    initial begin
        logic [15:0] w;
        int          op;
        void'($urandom(32'h5eed_0c7a));
        for (int i = 0; i < 8; i++) begin
            exp_stage[i] = '0;
            exp_out[i]   = '0;
        end
        wait_clks(10);
        check_all("R1 during reset");
        rst_n = 1'b1;
        wait_clks(4);
        check_all("R1 after reset");

        // R5: write every channel, outputs must not move
        for (int c = 0; c < 8; c++) send_frame({1'b0, 3'(c), 12'(12'h101 * (c + 1))}, 16);
        for (int i = 0; i < 8; i++) exp_out[i] = '0;
        check_all("R5 strobe high");
        // R6 / R2: one pulse moves all
        pulse_load();
        check_all("R6 transfer R2 routing");

        // R3: aborted frames of several lengths
        send_frame(16'h0FFF, 15);
        send_frame(16'h8000 | 16'h000F, 12);
        send_frame(16'h3ABC, 1);
        pulse_load();
        check_all("R3 aborted frames");

        // R4: over-long frame, only the first 16 bits count
        send_frame(16'h2123, 23);
        pulse_load();
        check_all("R4 trailing bits ignored");

        // R8: control word sets flags, leaves staging alone
        send_frame(16'h8000 | 16'h0009, 16);
        check_all("R8 flags");
        pulse_load();
        check_all("R8 staging unchanged");
        send_frame(16'h8006, 16);
        check_all("R8 flags second");

        // R7: strobe held low, outputs follow each write
        load_n = 1'b0;
        wait_clks(6);
        transparent = 1'b1;
        send_frame(16'h7E01, 16);
        check_all("R7 transparent write");
        send_frame(16'h0555, 16);
        check_all("R7 transparent second write");
        send_frame(16'h4AAA, 9);
        check_all("R7 R3 abort in transparent");
        load_n = 1'b1;
        transparent = 1'b0;
        wait_clks(6);

        // random mix
        for (int it = 0; it < 60; it++) begin
            w = 16'($urandom);
            w[15] = (($urandom % 4) == 0);
            op = int'($urandom % 8);
            if (op <= 3)       send_frame(w, 16);
            else if (op == 4)  send_frame(w, 1 + int'($urandom % 15));
            else if (op == 5)  send_frame(w, 17 + int'($urandom % 6));
            else               pulse_load();
            check_all("R2 R3 R4 R5 R6 R8 random");
        end
        pulse_load();
        check_all("R6 final transfer");

        finish_run();
    end

endmodule